// File: doc/BRIEF.md
# Vector Register Store Address Unit

This block handles one kind of instruction: a store that writes a single vector/floating-point register to memory using an immediate offset. It receives a 32-bit instruction word together with the general-purpose base register value that was read for it, the stack pointer, and the 128-bit vector register contents. From these it works out which addressing form the word encodes and flags any encoding it cannot accept. It then forms the effective address and presents one memory write request. When the form calls for it, it also returns the updated base address so the register file can write it back.

Both the instruction and the memory request use valid/ready handshakes. The unit takes one instruction at a time. `in_ready` is high only while the unit is idle, so upstream is held back for the whole life of an instruction: the request wait, the writeback pulse, and any error pulse. On the memory side, the request stays up with all of its fields frozen until `mem_ready` is sampled high. The memory side may hold `mem_ready` low for any number of cycles. The writeback and error outputs are one-cycle pulses with no handshake, so the consumer must take them in the cycle they appear.

Top module: `vst_imm_agu`

## Requirements
- R1: `in_ready` is high exactly when the unit is idle. An instruction is taken on a clock edge where `in_valid` and `in_ready` are both high. The unit shows at most one of the following per cycle: `in_ready`, `mem_valid`, `wb_valid`, `err_valid`.
- R2: A word is defined only when all of the following hold:
  - bits 29:27 are 111, bit 26 is 1 and bit 22 is 0;
  - either bits 25:24 are 01, or bits 25:24 are 00 with bit 21 equal to 0 and bits 11:10 equal to 01 or 11;
  - bit 23 is not set together with a nonzero bits 31:30.

  Any other word gives a one-cycle error with `err_undef`=1 and produces neither a memory request nor a writeback.
- R3: The scale is 4 when bit 23 is 1; otherwise it is bits 31:30. `mem_nbytes` is 1 shifted left by the scale (1, 2, 4, 8 or 16). `mem_be` has its lowest `mem_nbytes` bits set. `mem_data` carries the low `mem_nbytes` bytes of the vector register in their own lanes, and all higher bytes are zero.
- R4: When bits 25:24 are 01, the address is the base plus the 12-bit field in bits 21:10, zero-extended and multiplied by `mem_nbytes`. No writeback follows.
- R5: When bits 11:10 are 11, the unit pre-indexes. The address is the base plus the 9-bit field in bits 20:12, sign-extended and not scaled. A writeback of that same address follows.
- R6: When bits 11:10 are 01, the unit post-indexes. The address is the unmodified base. The writeback carries the base plus the sign-extended 9-bit field.
- R7: When bits 9:5 equal 31, the base is `in_sp` and `wb_to_sp` is 1. Otherwise the base is `in_gpr`. `wb_reg` always carries bits 9:5.
- R8: If the base is the stack pointer and `in_sp[3:0]` is nonzero, a defined word gives a one-cycle error with `err_align`=1, and no request or writeback. If the word is also undefined, only `err_undef` is reported.
- R9: `mem_tag_chk` is 1 for the pre- and post-index forms, and also whenever bits 9:5 are not 31.
- R10: While `mem_valid` is high and `mem_ready` is low, `mem_valid` stays high and the address, byte enables, byte count, data and tag flag do not change.
- R11: After a pre- or post-index request is accepted, `wb_valid` is high for exactly the next cycle, and the unit is idle in the cycle after that. After an accepted request in the scaled unsigned form, the unit is idle in the next cycle.
- R12: `err_valid` is high for exactly one cycle, in the cycle after the faulting instruction is taken. The unit is idle in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit idle, instruction will be taken |
| in_instr | input | 32 | Instruction word |
| in_gpr | input | XLEN | General register selected by bits 9:5 |
| in_sp | input | XLEN | Stack pointer value |
| in_vdata | input | 8*VBYTES | Vector register contents |
| mem_valid | output | 1 | Write request pending |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | XLEN | Byte address of the write |
| mem_nbytes | output | clog2(VBYTES)+1 | Byte count |
| mem_be | output | VBYTES | Byte-lane enables |
| mem_data | output | 8*VBYTES | Write data, unused lanes zero |
| mem_tag_chk | output | 1 | Access is subject to tag checking |
| wb_valid | output | 1 | Base writeback pulse |
| wb_to_sp | output | 1 | Writeback targets the stack pointer |
| wb_reg | output | 5 | Base register number |
| wb_addr | output | XLEN | Updated base value |
| err_valid | output | 1 | Fault pulse |
| err_undef | output | 1 | Fault cause: undefined encoding |
| err_align | output | 1 | Fault cause: stack pointer misaligned |

## Verification
The bench targets these corner cases:

- **Largest scaled offset in the 128-bit form.** A design that shifted by the size field alone, ignoring bit 23, would land at a quarter of the right address or less.
- **Signed immediate at -256 and at +255.** A design that zero-extended the immediate would land 512 bytes off. One that swapped pre- and post-indexing would send the updated address to memory.
- **Stack pointer as base, aligned and misaligned, and with an undefined word.** A design that selected the general register for number 31, raised the alignment fault for ordinary registers, or issued the store despite the fault would break the per-cycle match of the request and error outputs.
- **Long back-pressure stretches and wraparound past the top of the address space.** These expose a request that drifts while waiting, or a writeback that fires before acceptance or lasts two cycles.

// File: rtl/vst_pkg.sv
package vst_pkg;

  typedef enum logic [1:0] {
    FORM_UOFF = 2'd0,
    FORM_POST = 2'd1,
    FORM_PRE  = 2'd2,
    FORM_BAD  = 2'd3
  } form_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WB   = 2'd2,
    ST_ERR  = 2'd3
  } state_e;

  typedef struct packed {
    form_e      form;
    logic       undef;
    logic       wback;
    logic [2:0] scale;
    logic [4:0] rn;
  } dec_t;

  localparam logic [4:0] SP_REG_NUM = 5'd31;

endpackage

// File: rtl/vst_decode.sv
module vst_decode
  import vst_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [31:0]     instr,
  output dec_t            dec,
  output logic [XLEN-1:0] offset
);
  localparam int IMM9_W  = 9;
  localparam int IMM12_W = 12;

  logic              sig_ok;
  logic              bad_size;
  logic [IMM9_W-1:0] imm9;
  logic [IMM12_W-1:0] imm12;

  assign imm9  = instr[20:12];
  assign imm12 = instr[21:10];

  always_comb begin
    sig_ok   = (instr[29:27] == 3'b111) && instr[26] && !instr[22];
    bad_size = instr[23] && (instr[31:30] != 2'b00);

    if (instr[25:24] == 2'b01) begin
      dec.form = FORM_UOFF;
    end else if (instr[25:24] == 2'b00 && !instr[21]) begin
      case (instr[11:10])
        2'b01:   dec.form = FORM_POST;
        2'b11:   dec.form = FORM_PRE;
        default: dec.form = FORM_BAD;
      endcase
    end else begin
      dec.form = FORM_BAD;
    end

    dec.scale = instr[23] ? 3'd4 : {1'b0, instr[31:30]};
    dec.undef = !sig_ok || bad_size || (dec.form == FORM_BAD);
    dec.wback = (dec.form == FORM_POST) || (dec.form == FORM_PRE);
    dec.rn    = instr[9:5];

    if (dec.form == FORM_UOFF) begin
      offset = XLEN'(imm12) << dec.scale;
    end else begin
      offset = {{(XLEN-IMM9_W){imm9[IMM9_W-1]}}, imm9};
    end
  end

endmodule

// File: rtl/vst_addr_gen.sv
module vst_addr_gen
  import vst_pkg::*;
#(
  parameter int XLEN         = 64,
  parameter int SP_ALIGN_LOG2 = 4
) (
  input  logic [XLEN-1:0] gpr,
  input  logic [XLEN-1:0] sp,
  input  logic [4:0]      rn,
  input  form_e           form,
  input  logic [XLEN-1:0] offset,
  output logic [XLEN-1:0] acc_addr,
  output logic [XLEN-1:0] upd_addr,
  output logic            use_sp,
  output logic            sp_misalign
);
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] sum;

  always_comb begin
    use_sp      = (rn == SP_REG_NUM);
    base        = use_sp ? sp : gpr;
    sum         = base + offset;
    acc_addr    = (form == FORM_POST) ? base : sum;
    upd_addr    = sum;
    sp_misalign = use_sp && (sp[SP_ALIGN_LOG2-1:0] != '0);
  end

endmodule

// File: rtl/vst_lane_mask.sv
module vst_lane_mask #(
  parameter int VBYTES = 16
) (
  input  logic [2:0]                 scale,
  input  logic [VBYTES*8-1:0]        vdata,
  output logic [$clog2(VBYTES):0]    nbytes,
  output logic [VBYTES-1:0]          be,
  output logic [VBYTES*8-1:0]        data
);
  localparam int CNT_W = $clog2(VBYTES) + 1;

  assign nbytes = CNT_W'(1) << scale;

  for (genvar i = 0; i < VBYTES; i++) begin : g_lane
    assign be[i]          = (CNT_W'(i) < nbytes);
    assign data[i*8 +: 8] = be[i] ? vdata[i*8 +: 8] : 8'h00;
  end

endmodule

// File: rtl/vst_imm_agu.sv
module vst_imm_agu
  import vst_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int VBYTES = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [31:0]              in_instr,
  input  logic [XLEN-1:0]          in_gpr,
  input  logic [XLEN-1:0]          in_sp,
  input  logic [VBYTES*8-1:0]      in_vdata,
  output logic                     mem_valid,
  input  logic                     mem_ready,
  output logic [XLEN-1:0]          mem_addr,
  output logic [$clog2(VBYTES):0]  mem_nbytes,
  output logic [VBYTES-1:0]        mem_be,
  output logic [VBYTES*8-1:0]      mem_data,
  output logic                     mem_tag_chk,
  output logic                     wb_valid,
  output logic                     wb_to_sp,
  output logic [4:0]               wb_reg,
  output logic [XLEN-1:0]          wb_addr,
  output logic                     err_valid,
  output logic                     err_undef,
  output logic                     err_align
);
  localparam int VDATA_W = VBYTES * 8;
  localparam int CNT_W   = $clog2(VBYTES) + 1;

  state_e             state;
  dec_t               dec;
  logic [XLEN-1:0]    offset;
  logic [XLEN-1:0]    acc_addr;
  logic [XLEN-1:0]    upd_addr;
  logic               use_sp;
  logic               sp_misalign;
  logic [CNT_W-1:0]   lane_nbytes;
  logic [VBYTES-1:0]  lane_be;
  logic [VDATA_W-1:0] lane_data;
  logic               wback_q;
  logic               take;

  vst_decode #(.XLEN(XLEN)) u_decode (
    .instr  (in_instr),
    .dec    (dec),
    .offset (offset)
  );

  vst_addr_gen #(.XLEN(XLEN), .SP_ALIGN_LOG2(4)) u_addr (
    .gpr         (in_gpr),
    .sp          (in_sp),
    .rn          (dec.rn),
    .form        (dec.form),
    .offset      (offset),
    .acc_addr    (acc_addr),
    .upd_addr    (upd_addr),
    .use_sp      (use_sp),
    .sp_misalign (sp_misalign)
  );

  vst_lane_mask #(.VBYTES(VBYTES)) u_lanes (
    .scale  (dec.scale),
    .vdata  (in_vdata),
    .nbytes (lane_nbytes),
    .be     (lane_be),
    .data   (lane_data)
  );

  assign take      = in_valid && (state == ST_IDLE);
  assign in_ready  = (state == ST_IDLE);
  assign mem_valid = (state == ST_REQ);
  assign wb_valid  = (state == ST_WB);
  assign err_valid = (state == ST_ERR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      mem_addr    <= '0;
      mem_nbytes  <= '0;
      mem_be      <= '0;
      mem_data    <= '0;
      mem_tag_chk <= 1'b0;
      wb_to_sp    <= 1'b0;
      wb_reg      <= '0;
      wb_addr     <= '0;
      wback_q     <= 1'b0;
      err_undef   <= 1'b0;
      err_align   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (take) begin
            mem_addr    <= acc_addr;
            mem_nbytes  <= lane_nbytes;
            mem_be      <= lane_be;
            mem_data    <= lane_data;
            mem_tag_chk <= dec.wback || !use_sp;
            wb_to_sp    <= use_sp;
            wb_reg      <= dec.rn;
            wb_addr     <= upd_addr;
            wback_q     <= dec.wback;
            err_undef   <= dec.undef;
            err_align   <= !dec.undef && sp_misalign;
            state       <= (dec.undef || sp_misalign) ? ST_ERR : ST_REQ;
          end
        end
        ST_REQ: begin
          if (mem_ready) begin
            state <= wback_q ? ST_WB : ST_IDLE;
          end
        end
        ST_WB:   state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vst_imm_agu_chk.sv
module vst_imm_agu_chk #(
  parameter int XLEN   = 64,
  parameter int VBYTES = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_ready,
  input logic                    mem_valid,
  input logic                    mem_ready,
  input logic [XLEN-1:0]         mem_addr,
  input logic [$clog2(VBYTES):0] mem_nbytes,
  input logic [VBYTES-1:0]       mem_be,
  input logic [VBYTES*8-1:0]     mem_data,
  input logic                    mem_tag_chk,
  input logic                    wb_valid,
  input logic                    wb_to_sp,
  input logic [4:0]              wb_reg,
  input logic                    err_valid,
  input logic                    err_undef,
  input logic                    err_align
);

  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({in_ready, mem_valid, wb_valid, err_valid})); // R1

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_be)
      && $stable(mem_data) && $stable(mem_nbytes) && $stable(mem_tag_chk)); // R10

  AST_BE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> ($countones(mem_be) == int'(mem_nbytes))); // R3

  AST_WB_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(mem_valid && mem_ready)); // R11

  AST_WB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> in_ready); // R11

  AST_WB_SP_NUM: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && wb_to_sp |-> (wb_reg == 5'd31)); // R7

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> (err_undef != err_align)); // R8

  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |=> in_ready); // R12

endmodule

bind vst_imm_agu vst_imm_agu_chk #(.XLEN(XLEN), .VBYTES(VBYTES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_ready    (in_ready),
  .mem_valid   (mem_valid),
  .mem_ready   (mem_ready),
  .mem_addr    (mem_addr),
  .mem_nbytes  (mem_nbytes),
  .mem_be      (mem_be),
  .mem_data    (mem_data),
  .mem_tag_chk (mem_tag_chk),
  .wb_valid    (wb_valid),
  .wb_to_sp    (wb_to_sp),
  .wb_reg      (wb_reg),
  .err_valid   (err_valid),
  .err_undef   (err_undef),
  .err_align   (err_align)
);

// File: tb/vst_imm_agu_bench.sv
`timescale 1ns/1ps
module vst_imm_agu_bench;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [31:0]   in_instr = '0;
  logic [63:0]   in_gpr = '0;
  logic [63:0]   in_sp = '0;
  logic [127:0]  in_vdata = '0;
  logic          mem_valid;
  logic          mem_ready = 1'b0;
  logic [63:0]   mem_addr;
  logic [4:0]    mem_nbytes;
  logic [15:0]   mem_be;
  logic [127:0]  mem_data;
  logic          mem_tag_chk;
  logic          wb_valid;
  logic          wb_to_sp;
  logic [4:0]    wb_reg;
  logic [63:0]   wb_addr;
  logic          err_valid;
  logic          err_undef;
  logic          err_align;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  vst_imm_agu u_vst_imm_agu (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_instr(in_instr),
    .in_gpr(in_gpr), .in_sp(in_sp), .in_vdata(in_vdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_nbytes(mem_nbytes), .mem_be(mem_be), .mem_data(mem_data),
    .mem_tag_chk(mem_tag_chk),
    .wb_valid(wb_valid), .wb_to_sp(wb_to_sp), .wb_reg(wb_reg), .wb_addr(wb_addr),
    .err_valid(err_valid), .err_undef(err_undef), .err_align(err_align)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Reference model state: phase 0 idle, 1 request, 2 writeback, 3 error
  int           m_phase = 0;
  bit           m_wb;
  logic [63:0]  e_addr, e_wb;
  int           e_nb;
  logic [15:0]  e_be;
  logic [127:0] e_data;
  bit           e_tag, e_sp, e_undef, e_align;
  logic [4:0]   e_reg;

  task automatic model_take();
    logic [1:0]       sz;
    int               kind;
    bit               undef, align;
    longint unsigned  base;
    longint           off;
    sz = in_instr[31:30];
    if (in_instr[25:24] == 2'b01) kind = 0;
    else if (in_instr[25:24] == 2'b00 && !in_instr[21] && in_instr[10]) kind = in_instr[11] ? 2 : 1;
    else kind = -1;
    undef = (in_instr[29:26] != 4'b1111) || in_instr[22] || kind < 0 || (in_instr[23] && sz != 0);
    e_nb  = in_instr[23] ? 16 : (1 << sz);
    e_reg = in_instr[9:5];
    base  = (e_reg == 31) ? in_sp : in_gpr;
    if (kind == 0) off = longint'(in_instr[21:10]) * e_nb;
    else           off = longint'($signed(in_instr[20:12]));
    align   = !undef && e_reg == 31 && (in_sp % 16 != 0);
    e_addr  = (kind == 1) ? base : base + off;
    e_wb    = base + off;
    m_wb    = kind > 0;
    e_tag   = (kind > 0) || (e_reg != 31);
    e_sp    = (e_reg == 31);
    e_undef = undef;
    e_align = align;
    for (int i = 0; i < 16; i++) begin
      e_be[i] = (i < e_nb);
      e_data[i*8 +: 8] = (i < e_nb) ? in_vdata[i*8 +: 8] : 8'h00;
    end
    m_phase = (undef || align) ? 3 : 1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) m_phase = 0;
    else begin
      case (m_phase)
        0: if (in_valid) model_take();
        1: if (mem_ready) m_phase = m_wb ? 2 : 0;
        default: m_phase = 0;
      endcase
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && cyc > 0 && !done) begin
      chk(in_ready === (m_phase == 0), "R1 in_ready", 128'(in_ready), 128'(m_phase == 0));
      chk(mem_valid === (m_phase == 1), "R2 R8 mem_valid", 128'(mem_valid), 128'(m_phase == 1));
      chk(wb_valid === (m_phase == 2), "R11 wb_valid", 128'(wb_valid), 128'(m_phase == 2));
      chk(err_valid === (m_phase == 3), "R12 err_valid", 128'(err_valid), 128'(m_phase == 3));
      if (m_phase == 1) begin
        chk(mem_addr === e_addr, "R4 R5 R6 R7 R10 mem_addr", 128'(mem_addr), 128'(e_addr));
        chk(int'(mem_nbytes) == e_nb, "R3 mem_nbytes", 128'(mem_nbytes), 128'(e_nb));
        chk(mem_be === e_be, "R3 mem_be", 128'(mem_be), 128'(e_be));
        chk(mem_data === e_data, "R3 mem_data", mem_data, e_data);
        chk(mem_tag_chk === e_tag, "R9 mem_tag_chk", 128'(mem_tag_chk), 128'(e_tag));
      end
      if (m_phase == 2) begin
        chk(wb_addr === e_wb, "R5 R6 wb_addr", 128'(wb_addr), 128'(e_wb));
        chk(wb_to_sp === e_sp, "R7 wb_to_sp", 128'(wb_to_sp), 128'(e_sp));
        chk(wb_reg === e_reg, "R7 wb_reg", 128'(wb_reg), 128'(e_reg));
      end
      if (m_phase == 3) begin
        chk(err_undef === e_undef, "R2 err_undef", 128'(err_undef), 128'(e_undef));
        chk(err_align === e_align, "R8 err_align", 128'(err_align), 128'(e_align));
      end
    end
  end

  // Back-pressure pattern: ready low for two of every five cycles
  always @(negedge clk) mem_ready <= ((cyc % 5) > 1);

  function automatic logic [31:0] f_uoff(input logic [1:0] sz, input bit q, input logic [11:0] imm, input logic [4:0] rn);
    return {sz, 3'b111, 1'b1, 2'b01, q, 1'b0, imm, rn, 5'd9};
  endfunction

  function automatic logic [31:0] f_idx(input logic [1:0] sz, input bit q, input logic [8:0] imm, input bit pre, input logic [4:0] rn);
    return {sz, 3'b111, 1'b1, 2'b00, q, 1'b0, 1'b0, imm, pre, 1'b1, rn, 5'd4};
  endfunction

  task automatic send(input logic [31:0] ins, input logic [63:0] g, input logic [63:0] s);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_instr = ins;
    in_gpr   = g;
    in_sp    = s;
    in_vdata = {$urandom, $urandom, $urandom, $urandom};
    @(negedge clk);
    in_valid = 1'b0;
    in_instr = $urandom;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready === 1'b1, "R1 reset in_ready", 128'(in_ready), 128'd1);
    chk(mem_valid === 1'b0, "R1 reset mem_valid", 128'(mem_valid), 128'd0);
    chk(wb_valid === 1'b0 && err_valid === 1'b0, "R1 reset pulses", 128'({wb_valid, err_valid}), 128'd0);
    rst_n = 1'b1;
    // R4 scaled unsigned offsets, every width (R3)
    send(f_uoff(2'b00, 0, 12'd5,    5'd3), 64'h1000, 64'h0);
    send(f_uoff(2'b01, 0, 12'd4095, 5'd3), 64'h1000, 64'h0);
    send(f_uoff(2'b10, 0, 12'd7,    5'd1), 64'h2000, 64'h0);
    send(f_uoff(2'b11, 0, 12'h010,  5'd0), 64'h3000, 64'h0);
    send(f_uoff(2'b00, 1, 12'd4095, 5'd8), 64'h4000, 64'h0);
    // R5 pre-index at -256, R6 post-index at +255
    send(f_idx(2'b11, 0, 9'h100, 1, 5'd7), 64'h8000, 64'h0);
    send(f_idx(2'b10, 0, 9'h0FF, 0, 5'd2), 64'h9000, 64'h0);
    // R7 stack pointer base with writeback, aligned
    send(f_idx(2'b00, 1, 9'h1F0, 1, 5'd31), 64'h0, 64'h7FF0);
    // R8 misaligned stack pointer
    send(f_idx(2'b10, 0, 9'h004, 0, 5'd31), 64'h0, 64'h7FF8);
    // R9 stack pointer base without writeback: no tag check
    send(f_uoff(2'b11, 0, 12'd2, 5'd31), 64'h0, 64'h6000);
    // R2 undefined encodings
    send(f_uoff(2'b01, 1, 12'd1, 5'd3), 64'h1000, 64'h0);
    send({2'b10, 3'b111, 1'b1, 2'b00, 2'b00, 1'b0, 9'h001, 2'b00, 5'd3, 5'd1}, 64'h1000, 64'h0);
    send(f_uoff(2'b10, 0, 12'd1, 5'd3) | 32'h0040_0000, 64'h1000, 64'h0);
    send({2'b10, 3'b111, 1'b1, 2'b10, 2'b00, 12'd1, 5'd3, 5'd1}, 64'h1000, 64'h0);
    // R8 undefined wins over misalignment
    send(f_uoff(2'b11, 1, 12'd1, 5'd31), 64'h0, 64'h7FF3);
    // R6 wraparound past the top of the address space
    send(f_idx(2'b01, 0, 9'h0FF, 0, 5'd6), 64'hFFFF_FFFF_FFFF_FFF0, 64'h0);
    send(f_idx(2'b01, 0, 9'h0FF, 1, 5'd6), 64'hFFFF_FFFF_FFFF_FFF0, 64'h0);
    repeat (12) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule